// File: doc/BRIEF.md
# Dual Timer and Interrupt Controller

This peripheral holds two free-running 16-bit counters and one interrupt controller with four sources: the wrap event of each counter and two external request lines. A single 16-bit control word configures everything. It has one clear bit, one enable bit and one 2-bit prescaler code per source or counter, plus a run bit and a reset bit for each counter. Each counter has a period input. Each source has its own vector address input.

Sources raise sticky pending flags. Fixed-priority selection offers one enabled pending source to the core as a valid/ready transfer. `irq_req` is the valid and `irq_ack` is the ready. While `irq_req` is high and `irq_ack` is low, the offer is back-pressured: `irq_vector` must not change and the offer cannot be withdrawn. When the core accepts, the block pulses `save_pc_stb` in the same cycle and captures `core_pc` into `saved_pc`. It then offers nothing more until the core signals `irq_ret`.

Top module: `tick_irq_unit`

## Requirements
- R1: After reset, `count_t0`, `count_t1`, `saved_pc` are 0 and `irq_req`, `save_pc_stb` are low.
- R2: Counter 0 advances by one per prescaled tick while `ctrl_word[12]` is set, and counter 1 does so while `ctrl_word[13]` is set. A counter whose run bit is clear keeps its value.
- R3: Prescaler code `ctrl_word[9:8]` (counter 0) or `ctrl_word[11:10]` (counter 1) gives one increment every 1, 8, 64 or 256 clocks for codes 0, 1, 2 and 3.
- R4: On a tick with the count at or above its period, the count goes to 0 and that counter's pending flag is set.
- R5: While `ctrl_word[14]` (counter 0) or `ctrl_word[15]` (counter 1) is set, the count and its prescaler phase are held at 0, even if the run bit is set.
- R6: Each `ext_irq` bit passes through a two-flop synchronizer. A rising edge sets its pending flag. A level held high yields only one request.
- R7: Pending flags are set whether or not the source is enabled. A source requests only while its enable bit is set: bits 4 and 5 for counters 0 and 1, bits 6 and 7 for external lines 0 and 1.
- R8: While clear bit 0, 1, 2 or 3 (counter 0, counter 1, external 0, external 1) is high, that pending flag is forced low. The clear overrides a simultaneous set.
- R9: When several enabled sources are pending, they are served in the order counter 0, counter 1, external 0, external 1. `irq_vector` is that source's vector input.
- R10: While `irq_req` is high and `irq_ack` is low, `irq_req` and `irq_vector` stay unchanged. On acceptance, `save_pc_stb` is high in that cycle, `saved_pc` holds `core_pc` from the next cycle, and the source's pending flag is cleared.
- R11: After an acceptance, `irq_req` stays low until `irq_ret` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 16 | Packed control word |
| period_t0 | input | 16 | Counter 0 period |
| period_t1 | input | 16 | Counter 1 period |
| vec_t0 | input | 16 | Vector for counter 0 wrap |
| vec_t1 | input | 16 | Vector for counter 1 wrap |
| vec_x0 | input | 16 | Vector for external line 0 |
| vec_x1 | input | 16 | Vector for external line 1 |
| ext_irq | input | 2 | Asynchronous external request lines |
| core_pc | input | 16 | Current program counter of the core |
| irq_ack | input | 1 | Ready: core accepts the offered request |
| irq_ret | input | 1 | Core has returned from the handler |
| count_t0 | output | 16 | Counter 0 value |
| count_t1 | output | 16 | Counter 1 value |
| irq_req | output | 1 | Valid: a request is offered |
| irq_vector | output | 16 | Vector of the offered source |
| save_pc_stb | output | 1 | Strobe to save the PC, high on acceptance |
| saved_pc | output | 16 | PC captured at acceptance |

## Verification
The bench counts exact tick spacing for prescaler codes 1, 2 and 3, one cycle before and one cycle on the increment. An off-by-one in the prescaler limit would shift the count by a full tick. It makes three sources pending while they are masked and then unmasks them together. A wrong priority encoder would present the vectors out of order, and a mask applied to the flag instead of the request would lose them. It holds an external line high for many cycles, so a level detector would produce repeated unexpected requests. It delays `irq_ack` by a cycle and delays `irq_ret` by several, so a controller that drops the offer or pre-empts a handler in progress is caught.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  localparam int PSW = 8;      // prescale phase counter width
  localparam int NSRC = 4;     // interrupt sources
  localparam int SELW = $clog2(NSRC);

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_OFFER = 2'd1,
    ARB_BUSY  = 2'd2
  } arb_state_e;

  // terminal phase for each prescaler code
  function automatic logic [PSW-1:0] presc_limit(input logic [1:0] code);
    case (code)
      2'd0: presc_limit = PSW'(0);
      2'd1: presc_limit = PSW'(7);
      2'd2: presc_limit = PSW'(63);
      default: presc_limit = PSW'(255);
    endcase
  endfunction
endpackage

// File: rtl/tick_timer.sv
module tick_timer
  import tick_irq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          hold_zero,
  input  logic [1:0]    presc_code,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] count,
  output logic          wrap
);
  logic [PSW-1:0] phase_q;
  logic [CW-1:0]  cnt_q;
  logic           tick;

  assign tick  = run && !hold_zero && (phase_q >= presc_limit(presc_code));
  assign wrap  = tick && (cnt_q >= period);
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      cnt_q   <= '0;
    end else if (hold_zero) begin
      phase_q <= '0;
      cnt_q   <= '0;
    end else if (run) begin
      if (tick) begin
        phase_q <= '0;
        cnt_q   <= wrap ? '0 : cnt_q + 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  AST_RESET_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hold_zero |=> (count == '0)); // R5
  AST_STOPPED_IS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold_zero) |=> $stable(count)); // R2
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0)); // R4
endmodule

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] && !sh_q[STAGES];

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R6
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import tick_irq_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int AW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   src_event,
  input  logic [N-1:0]   src_clear,
  input  logic [N-1:0]   src_enable,
  input  logic [N*AW-1:0] vec_flat,
  input  logic [AW-1:0]  core_pc,
  input  logic           ack,
  input  logic           ret,
  output logic           req,
  output logic [AW-1:0]  vector,
  output logic           save_stb,
  output logic [AW-1:0]  saved_pc
);
  localparam int SW = (N > 1) ? $clog2(N) : 1;

  arb_state_e     state_q;
  logic [SW-1:0]  sel_q;
  logic [SW-1:0]  pick;
  logic [N-1:0]   pend_q;
  logic [N-1:0]   live;
  logic [AW-1:0]  saved_q;
  logic           accept;

  assign live   = pend_q & src_enable;
  assign req    = (state_q == ARB_OFFER);
  assign accept = req && ack;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (live[i]) pick = SW'(i);
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_pend
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               pend_q[g] <= 1'b0;
        else if (src_clear[g])                    pend_q[g] <= 1'b0;
        else if (src_event[g])                    pend_q[g] <= 1'b1;
        else if (accept && (sel_q == SW'(g)))     pend_q[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      sel_q   <= '0;
      saved_q <= '0;
    end else begin
      case (state_q)
        ARB_IDLE: if (|live) begin
          sel_q   <= pick;
          state_q <= ARB_OFFER;
        end
        ARB_OFFER: if (ack) begin
          saved_q <= core_pc;
          state_q <= ARB_BUSY;
        end
        ARB_BUSY: if (ret) state_q <= ARB_IDLE;
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  assign vector   = vec_flat[sel_q*AW +: AW];
  assign save_stb = accept;
  assign saved_pc = saved_q;

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(vector))); // R10
  AST_PC_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (saved_pc == $past(core_pc))); // R10
  AST_QUIET_IN_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_BUSY && !ret) |=> !req); // R11
  AST_OFFER_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> ($past(state_q) == ARB_IDLE)); // R11
endmodule

// File: rtl/tick_irq_unit.sv
module tick_irq_unit
  import tick_irq_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   ctrl_word,
  input  logic [CW-1:0] period_t0,
  input  logic [CW-1:0] period_t1,
  input  logic [AW-1:0] vec_t0,
  input  logic [AW-1:0] vec_t1,
  input  logic [AW-1:0] vec_x0,
  input  logic [AW-1:0] vec_x1,
  input  logic [1:0]    ext_irq,
  input  logic [AW-1:0] core_pc,
  input  logic          irq_ack,
  input  logic          irq_ret,
  output logic [CW-1:0] count_t0,
  output logic [CW-1:0] count_t1,
  output logic          irq_req,
  output logic [AW-1:0] irq_vector,
  output logic          save_pc_stb,
  output logic [AW-1:0] saved_pc
);
  localparam int NT = 2;   // counters
  localparam int NX = 2;   // external lines

  logic [NT-1:0]      t_wrap;
  logic [NX-1:0]      x_rise;
  logic [NT*CW-1:0]   periods;
  logic [NT*CW-1:0]   counts;

  assign periods = {period_t1, period_t0};

  generate
    for (genvar t = 0; t < NT; t++) begin : g_tmr
      tick_timer #(.CW(CW)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl_word[12 + t]),
        .hold_zero  (ctrl_word[14 + t]),
        .presc_code (ctrl_word[8 + 2*t +: 2]),
        .period     (periods[t*CW +: CW]),
        .count      (counts[t*CW +: CW]),
        .wrap       (t_wrap[t])
      );
    end
    for (genvar x = 0; x < NX; x++) begin : g_ext
      edge_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_irq[x]),
        .rise  (x_rise[x])
      );
    end
  endgenerate

  assign count_t0 = counts[0 +: CW];
  assign count_t1 = counts[CW +: CW];

  irq_arbiter #(.N(NT + NX), .AW(AW)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_event  ({x_rise, t_wrap}),
    .src_clear  (ctrl_word[3:0]),
    .src_enable (ctrl_word[7:4]),
    .vec_flat   ({vec_x1, vec_x0, vec_t1, vec_t0}),
    .core_pc    (core_pc),
    .ack        (irq_ack),
    .ret        (irq_ret),
    .req        (irq_req),
    .vector     (irq_vector),
    .save_stb   (save_pc_stb),
    .saved_pc   (saved_pc)
  );

  AST_STROBE_NEEDS_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    save_pc_stb |-> (irq_req && irq_ack)); // R10
endmodule

// File: tb/tb_tick_irq_unit.sv
module tb_tick_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ctrl_word = '0;
  logic [15:0] period_t0 = '0, period_t1 = '0;
  logic [15:0] vec_t0 = 16'h1100, vec_t1 = 16'h2200;
  logic [15:0] vec_x0 = 16'h3300, vec_x1 = 16'h4400;
  logic [1:0]  ext_irq = '0;
  logic [15:0] core_pc = 16'h0100;
  logic        irq_ack = 1'b0, irq_ret = 1'b0;
  logic [15:0] count_t0, count_t1, irq_vector, saved_pc;
  logic        irq_req, save_pc_stb;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  bit mon_busy = 0;
  logic [15:0] exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) core_pc <= core_pc + 16'd3;

  tick_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
    .period_t0(period_t0), .period_t1(period_t1),
    .vec_t0(vec_t0), .vec_t1(vec_t1), .vec_x0(vec_x0), .vec_x1(vec_x1),
    .ext_irq(ext_irq), .core_pc(core_pc), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .count_t0(count_t0), .count_t1(count_t1), .irq_req(irq_req),
    .irq_vector(irq_vector), .save_pc_stb(save_pc_stb), .saved_pc(saved_pc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ext(input int idx);
    ext_irq[idx] = 1'b1;
    step(3);
    ext_irq[idx] = 1'b0;
    step(4);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 400; i++) begin
      if (exp_q.size() == 0 && !mon_busy) break;
      @(negedge clk);
    end
    chk(exp_q.size() == 0 && !mon_busy, req, "expected requests served",
        exp_q.size(), 0);
  endtask

  // monitor: plays the core, pops expectations from the scoreboard
  initial begin : monitor
    logic [15:0] e, held, pcv;
    forever begin
      @(negedge clk);
      if (rst_n && irq_req) begin
        mon_busy = 1;
        if (exp_q.size() == 0) begin
          chk(0, "R9", "unexpected request vector", irq_vector, 0);
        end else begin
          e = exp_q.pop_front();
          chk(irq_vector == e, "R9", "vector order", irq_vector, e);
        end
        held = irq_vector;
        @(negedge clk);
        chk(irq_req && irq_vector == held, "R10", "offer held under back-pressure",
            irq_vector, held);
        irq_ack = 1'b1;
        pcv = core_pc;
        #1;
        chk(save_pc_stb == 1'b1, "R10", "save strobe on accept", save_pc_stb, 1);
        @(negedge clk);
        irq_ack = 1'b0;
        chk(saved_pc == pcv, "R10", "saved pc", saved_pc, pcv);
        for (int k = 0; k < 6; k++) begin
          chk(irq_req == 1'b0, "R11", "no offer before return", irq_req, 0);
          @(negedge clk);
        end
        irq_ret = 1'b1;
        @(negedge clk);
        irq_ret = 1'b0;
        mon_busy = 0;
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(count_t0 == 0 && count_t1 == 0, "R1", "counts after reset", count_t0, 0);
    chk(!irq_req && !save_pc_stb, "R1", "no request after reset", irq_req, 0);
    chk(saved_pc == 0, "R1", "saved pc after reset", saved_pc, 0);

    // R2 / R4 counting and wrap, prescaler code 0
    period_t0 = 16'd5;
    ctrl_word = 16'h1000;
    step(3);
    chk(count_t0 == 3, "R2", "counter 0 after 3 ticks", count_t0, 3);
    step(3);
    chk(count_t0 == 0, "R4", "counter 0 wraps after period", count_t0, 0);
    step(2);
    ctrl_word = 16'h0000;
    step(5);
    chk(count_t0 == 2, "R2", "stopped counter holds", count_t0, 2);
    // R5 reset overrides run
    ctrl_word = 16'h5000;
    step(5);
    chk(count_t0 == 0, "R5", "reset bit holds zero with run set", count_t0, 0);
    ctrl_word = 16'h0001;   // drop pending from the wrap above
    step(1);

    // R3 prescaler codes on counter 1
    period_t1 = 16'd1000;
    ctrl_word = 16'h8000; step(1);
    ctrl_word = 16'h2400; step(15);
    chk(count_t1 == 1, "R3", "code 1 after 15 clocks", count_t1, 1);
    step(1);
    chk(count_t1 == 2, "R3", "code 1 after 16 clocks", count_t1, 2);
    ctrl_word = 16'h8000; step(1);
    ctrl_word = 16'h2800; step(128);
    chk(count_t1 == 2, "R3", "code 2 after 128 clocks", count_t1, 2);
    ctrl_word = 16'h8000; step(1);
    ctrl_word = 16'h2C00; step(511);
    chk(count_t1 == 1, "R3", "code 3 after 511 clocks", count_t1, 1);
    step(1);
    chk(count_t1 == 2, "R3", "code 3 after 512 clocks", count_t1, 2);
    ctrl_word = 16'h8000; step(1);
    ctrl_word = 16'h0000; step(1);

    // R4 / R10 counter 0 interrupt
    period_t0 = 16'd3;
    exp_q.push_back(vec_t0);
    ctrl_word = 16'h1010;
    step(4);
    chk(count_t0 == 0, "R4", "wrap at period 3", count_t0, 0);
    ctrl_word = 16'h0010;
    drain("R4");
    ctrl_word = 16'h0000;

    // R6 external line 0, then a long level on line 1
    ctrl_word = 16'h0040;
    exp_q.push_back(vec_x0);
    pulse_ext(0);
    drain("R6");
    ctrl_word = 16'h0080;
    exp_q.push_back(vec_x1);
    ext_irq[1] = 1'b1;
    step(40);
    ext_irq[1] = 1'b0;
    drain("R6");
    step(20);
    chk(irq_req == 0, "R6", "held level gives one request", irq_req, 0);
    ctrl_word = 16'h0000;

    // R7 / R9 masked pending, then unmasked together
    period_t1 = 16'd1;
    ctrl_word = 16'h8000; step(1);
    ctrl_word = 16'h2000; step(2);
    ctrl_word = 16'h0000;
    pulse_ext(0);
    pulse_ext(1);
    step(10);
    chk(irq_req == 0, "R7", "masked sources stay quiet", irq_req, 0);
    exp_q.push_back(vec_t1);
    exp_q.push_back(vec_x0);
    exp_q.push_back(vec_x1);
    ctrl_word = 16'h00F0;
    drain("R9");
    ctrl_word = 16'h0000;

    // R8 clear bit removes a pending external request
    pulse_ext(1);
    step(2);
    ctrl_word = 16'h0008; step(1);
    ctrl_word = 16'h0080; step(20);
    chk(irq_req == 0, "R8", "cleared flag gives no request", irq_req, 0);
    ctrl_word = 16'h0000;
    step(5);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule